// File: doc/BRIEF.md
# Free-Hole Memory Allocator Engine

This engine keeps a small table of free memory holes, each entry holding a start address, a size and a valid bit. It serves a contiguous address pool. An allocate request names a size and one of four search policies. The engine walks the table one entry per clock, picks a hole, and returns the start address of the granted region. Whatever is left of the chosen hole stays in the table as a smaller hole.

A free request names a start address and a size. The engine scans the whole table for a hole that ends exactly at the freed region and for one that starts exactly where it ends. It then folds the region into those neighbours, or places it in the first empty entry.

Each request ends with a one-cycle completion pulse that carries a success or failure flag. Requests are accepted only while the engine is idle. After reset the table holds one hole that covers the whole pool, in entry 0.

Top module: `hole_alloc_engine`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and the table holds one hole of `POOL_SIZE` units at `BASE_ADDR` in entry 0; every other entry is empty.
- R2: Policy 0 (first-fit) grants the start of the lowest-index valid hole whose size is at least the request and stops scanning there.
- R3: Policy 1 (next-fit) starts its scan at the table index of the hole granted by the most recent successful policy-0 or policy-1 allocation (index 0 after reset), wraps past the last entry and grants the first hole that fits.
- R4: Policy 2 (best-fit) scans every entry and grants the smallest hole that fits; among equal sizes the lowest index wins.
- R5: Policy 3 (worst-fit) scans every entry and grants the largest hole, lowest index on ties, and fails when that hole is smaller than the request.
- R6: A granted hole of size S for request size R becomes a hole at start+R of size S-R; when S equals R its entry is emptied.
- R7: A freed region is merged with a hole that ends at its start, with a hole that starts at its end, or with both into one entry, and the other entry is emptied.
- R8: A freed region with no adjacent hole is written into the lowest-index empty entry.
- R9: A free request that has no adjacent hole while all entries are valid fails and leaves the table unchanged.
- R10: An allocation fails when no single hole is large enough, even when the total free space would cover it.
- R11: Each accepted request (`req_free_i` 0 = allocate, 1 = free) produces exactly one cycle of `done_o`, with `ok_o` valid in that cycle; `busy_o` is high from the cycle after acceptance through the done cycle, and requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_free_i | input | 1 | 0 = allocate, 1 = free |
| req_policy_i | input | 2 | 0 first-fit, 1 next-fit, 2 best-fit, 3 worst-fit |
| req_addr_i | input | ADDR_W | Start address of a region being freed |
| req_size_i | input | ADDR_W | Requested or freed size |
| busy_o | output | 1 | Engine is scanning or committing |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Success flag, valid with done_o |
| grant_addr_o | output | ADDR_W | Granted start address, valid with done_o and ok_o on allocations |

## Verification
On every cycle the assertions check the request handshake: done comes as a single pulse, only after an accepted request and only while busy, and busy stays up until done. They also check that every granted region lies inside the pool. The choice of hole under each policy, the next-fit resume point, the leftover sizes, the merges and the refusal on a full table depend on the table contents. Only the bench's scripted sequence can show these, because each later grant address and each failure reveals what an earlier step left behind.

// File: rtl/hole_alloc_pkg.sv
package hole_alloc_pkg;
  typedef enum logic [1:0] {
    POL_FIRST = 2'd0,
    POL_NEXT  = 2'd1,
    POL_BEST  = 2'd2,
    POL_WORST = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_COMMIT = 2'd2
  } state_e;
endpackage

// File: rtl/hole_table.sv
module hole_table #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 10,
  parameter int BASE_ADDR = 0,
  parameter int POOL_SIZE = 1000,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_start_o,
  output logic [ADDR_W-1:0] rd_size_o,
  input  logic              wa_en_i,
  input  logic [IDX_W-1:0]  wa_idx_i,
  input  logic              wa_valid_i,
  input  logic [ADDR_W-1:0] wa_start_i,
  input  logic [ADDR_W-1:0] wa_size_i,
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i
);
  logic [N_ENTRIES-1:0]             valid_all;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] start_all;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] size_all;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic              vld_q;
    logic [ADDR_W-1:0] st_q, sz_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= (g == 0);
        st_q  <= (g == 0) ? ADDR_W'(BASE_ADDR) : '0;
        sz_q  <= (g == 0) ? ADDR_W'(POOL_SIZE) : '0;
      end else if (wa_en_i && wa_idx_i == IDX_W'(g)) begin
        vld_q <= wa_valid_i;
        st_q  <= wa_start_i;
        sz_q  <= wa_size_i;
      end else if (wb_en_i && wb_idx_i == IDX_W'(g)) begin
        vld_q <= 1'b0;
      end
    end
    assign valid_all[g] = vld_q;
    assign start_all[g] = st_q;
    assign size_all[g]  = sz_q;
  end

  assign rd_valid_o = valid_all[rd_idx_i];
  assign rd_start_o = start_all[rd_idx_i];
  assign rd_size_o  = size_all[rd_idx_i];
endmodule

// File: rtl/fit_judge.sv
module fit_judge
  import hole_alloc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  policy_e           policy_i,
  input  logic              ent_valid_i,
  input  logic [ADDR_W-1:0] ent_size_i,
  input  logic [ADDR_W-1:0] req_size_i,
  input  logic              have_i,
  input  logic [ADDR_W-1:0] cur_size_i,
  output logic              take_o
);
  logic fits;
  assign fits = ent_valid_i && (ent_size_i >= req_size_i);

  // strict compares keep the lowest index on ties
  always_comb begin
    unique case (policy_i)
      POL_BEST:  take_o = fits && (!have_i || ent_size_i < cur_size_i);
      POL_WORST: take_o = fits && (!have_i || ent_size_i > cur_size_i);
      default:   take_o = fits;
    endcase
  end
endmodule

// File: rtl/hole_alloc_engine.sv
module hole_alloc_engine
  import hole_alloc_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 10,
  parameter int BASE_ADDR = 0,
  parameter int POOL_SIZE = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_free_i,
  input  logic [1:0]        req_policy_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W-1:0] req_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [ADDR_W-1:0] grant_addr_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  state_e            state_q;
  policy_e           pol_q;
  logic              op_free_q;
  logic [ADDR_W-1:0] addr_q, size_q;
  logic [IDX_W-1:0]  idx_q, cnt_q, rover_q;

  logic              have_q;
  logic [IDX_W-1:0]  sel_idx_q;
  logic [ADDR_W-1:0] sel_start_q, sel_size_q;
  logic              prv_have_q, suc_have_q, slot_have_q;
  logic [IDX_W-1:0]  prv_idx_q, suc_idx_q, slot_idx_q;
  logic [ADDR_W-1:0] prv_start_q, prv_size_q, suc_size_q;

  logic              rd_valid;
  logic [ADDR_W-1:0] rd_start, rd_size;
  logic              take, is_seq, last, prev_hit, succ_hit;

  logic              wa_en, wa_valid, wb_en;
  logic [IDX_W-1:0]  wa_idx, wb_idx;
  logic [ADDR_W-1:0] wa_start, wa_size;
  logic              ok_c;

  hole_table #(
    .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .POOL_SIZE(POOL_SIZE)
  ) u_table (
    .clk_i, .rst_ni,
    .rd_idx_i(idx_q), .rd_valid_o(rd_valid), .rd_start_o(rd_start), .rd_size_o(rd_size),
    .wa_en_i(wa_en), .wa_idx_i(wa_idx), .wa_valid_i(wa_valid),
    .wa_start_i(wa_start), .wa_size_i(wa_size),
    .wb_en_i(wb_en), .wb_idx_i(wb_idx)
  );

  fit_judge #(.ADDR_W(ADDR_W)) u_judge (
    .policy_i(pol_q), .ent_valid_i(rd_valid), .ent_size_i(rd_size),
    .req_size_i(size_q), .have_i(have_q), .cur_size_i(sel_size_q), .take_o(take)
  );

  assign is_seq   = (pol_q == POL_FIRST) || (pol_q == POL_NEXT);
  assign last     = (cnt_q == LAST_IDX);
  assign prev_hit = rd_valid && ({1'b0, rd_start} + {1'b0, rd_size} == {1'b0, addr_q});
  assign succ_hit = rd_valid && ({1'b0, rd_start} == {1'b0, addr_q} + {1'b0, size_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pol_q       <= POL_FIRST;
      op_free_q   <= 1'b0;
      addr_q      <= '0;
      size_q      <= '0;
      idx_q       <= '0;
      cnt_q       <= '0;
      rover_q     <= '0;
      have_q      <= 1'b0;
      sel_idx_q   <= '0;
      sel_start_q <= '0;
      sel_size_q  <= '0;
      prv_have_q  <= 1'b0;
      suc_have_q  <= 1'b0;
      slot_have_q <= 1'b0;
      prv_idx_q   <= '0;
      suc_idx_q   <= '0;
      slot_idx_q  <= '0;
      prv_start_q <= '0;
      prv_size_q  <= '0;
      suc_size_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q     <= ST_SCAN;
          op_free_q   <= req_free_i;
          pol_q       <= policy_e'(req_policy_i);
          addr_q      <= req_addr_i;
          size_q      <= req_size_i;
          cnt_q       <= '0;
          idx_q       <= (!req_free_i && policy_e'(req_policy_i) == POL_NEXT) ? rover_q : '0;
          have_q      <= 1'b0;
          prv_have_q  <= 1'b0;
          suc_have_q  <= 1'b0;
          slot_have_q <= 1'b0;
        end
        ST_SCAN: begin
          cnt_q <= cnt_q + 1'b1;
          idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
          if (!op_free_q) begin
            if (take) begin
              have_q      <= 1'b1;
              sel_idx_q   <= idx_q;
              sel_start_q <= rd_start;
              sel_size_q  <= rd_size;
            end
            if (last || (take && is_seq)) state_q <= ST_COMMIT;
          end else begin
            if (prev_hit && !prv_have_q) begin
              prv_have_q  <= 1'b1;
              prv_idx_q   <= idx_q;
              prv_start_q <= rd_start;
              prv_size_q  <= rd_size;
            end
            if (succ_hit && !suc_have_q) begin
              suc_have_q <= 1'b1;
              suc_idx_q  <= idx_q;
              suc_size_q <= rd_size;
            end
            if (!rd_valid && !slot_have_q) begin
              slot_have_q <= 1'b1;
              slot_idx_q  <= idx_q;
            end
            if (last) state_q <= ST_COMMIT;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          if (!op_free_q && have_q && is_seq) rover_q <= sel_idx_q;
        end
      endcase
    end
  end

  always_comb begin
    wa_en    = 1'b0;
    wa_idx   = '0;
    wa_valid = 1'b1;
    wa_start = '0;
    wa_size  = '0;
    wb_en    = 1'b0;
    wb_idx   = '0;
    if (state_q == ST_COMMIT) begin
      if (!op_free_q) begin
        wa_en    = have_q;
        wa_idx   = sel_idx_q;
        wa_valid = (sel_size_q != size_q);
        wa_start = sel_start_q + size_q;
        wa_size  = sel_size_q - size_q;
      end else if (prv_have_q) begin
        wa_en    = 1'b1;
        wa_idx   = prv_idx_q;
        wa_start = prv_start_q;
        wa_size  = prv_size_q + size_q + (suc_have_q ? suc_size_q : '0);
        wb_en    = suc_have_q;
        wb_idx   = suc_idx_q;
      end else if (suc_have_q) begin
        wa_en    = 1'b1;
        wa_idx   = suc_idx_q;
        wa_start = addr_q;
        wa_size  = suc_size_q + size_q;
      end else if (slot_have_q) begin
        wa_en    = 1'b1;
        wa_idx   = slot_idx_q;
        wa_start = addr_q;
        wa_size  = size_q;
      end
    end
  end

  assign ok_c         = op_free_q ? (prv_have_q || suc_have_q || slot_have_q) : have_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_COMMIT);
  assign ok_o         = done_o && ok_c;
  assign grant_addr_o = sel_start_q;
endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
  parameter int ADDR_W    = 10,
  parameter int BASE_ADDR = 0,
  parameter int POOL_SIZE = 1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_free_i,
  input logic [ADDR_W-1:0] req_size_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ok_o,
  input logic [ADDR_W-1:0] grant_addr_o
);
  localparam logic [ADDR_W:0] POOL_END = (ADDR_W+1)'(BASE_ADDR + POOL_SIZE);
  localparam logic [ADDR_W:0] POOL_LO  = (ADDR_W+1)'(BASE_ADDR);

  logic              pend_q, free_q;
  logic [ADDR_W-1:0] sz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      free_q <= 1'b0;
      sz_q   <= '0;
    end else if (req_valid_i && !busy_o) begin
      pend_q <= 1'b1;
      free_q <= req_free_i;
      sz_q   <= req_size_i;
    end else if (done_o) begin
      pend_q <= 1'b0;
    end
  end

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r11_done_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pend_q);
  a_r11_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r11_start_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
  a_r6_grant_in_pool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o && !free_q) |->
      ({1'b0, grant_addr_o} >= POOL_LO) && ({1'b0, grant_addr_o} + {1'b0, sz_q} <= POOL_END));
endmodule

bind hole_alloc_engine hole_alloc_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .POOL_SIZE(POOL_SIZE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_free_i(req_free_i),
  .req_size_i(req_size_i), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
  .grant_addr_o(grant_addr_o)
);

// File: tb/hole_alloc_engine_tb_top.sv
module hole_alloc_engine_tb_top;
  localparam int AW = 10;
  localparam int NV = 43;

  typedef struct packed {
    logic          fr;
    logic [1:0]    pol;
    logic [AW-1:0] addr;
    logic [AW-1:0] size;
    logic          ok;
    logic [AW-1:0] grant;
    logic [3:0]    req;
  } vec_t;

  // policy: 0 first, 1 next, 2 best, 3 worst; fr: 0 alloc, 1 free
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 10'd0,   10'd100, 1'b1, 10'd0,   4'd2},  // R2
    '{1'b0, 2'd0, 10'd0,   10'd200, 1'b1, 10'd100, 4'd2},  // R2
    '{1'b0, 2'd0, 10'd0,   10'd50,  1'b1, 10'd300, 4'd6},  // R6 remainder
    '{1'b0, 2'd0, 10'd0,   10'd150, 1'b1, 10'd350, 4'd6},
    '{1'b0, 2'd0, 10'd0,   10'd100, 1'b1, 10'd500, 4'd6},
    '{1'b1, 2'd0, 10'd100, 10'd200, 1'b1, 10'd0,   4'd8},  // R8 new entry
    '{1'b1, 2'd0, 10'd350, 10'd150, 1'b1, 10'd0,   4'd8},
    '{1'b0, 2'd2, 10'd0,   10'd120, 1'b1, 10'd350, 4'd4},  // R4 smallest
    '{1'b0, 2'd3, 10'd0,   10'd100, 1'b1, 10'd600, 4'd5},  // R5 largest
    '{1'b0, 2'd0, 10'd0,   10'd250, 1'b1, 10'd700, 4'd2},
    '{1'b0, 2'd0, 10'd0,   10'd100, 1'b1, 10'd100, 4'd2},  // skips small entry 0
    '{1'b0, 2'd1, 10'd0,   10'd20,  1'b1, 10'd200, 4'd3},  // R3 resumes at entry 1
    '{1'b0, 2'd0, 10'd0,   10'd20,  1'b1, 10'd950, 4'd2},
    '{1'b0, 2'd1, 10'd0,   10'd40,  1'b1, 10'd220, 4'd3},  // R3 from entry 0
    '{1'b0, 2'd2, 10'd0,   10'd30,  1'b1, 10'd970, 4'd4},  // R4 tie -> lowest, exact
    '{1'b0, 2'd3, 10'd0,   10'd50,  1'b0, 10'd0,   4'd5},  // R5 too small
    '{1'b0, 2'd2, 10'd0,   10'd45,  1'b0, 10'd0,   4'd10}, // R10 total 70
    '{1'b0, 2'd0, 10'd0,   10'd40,  1'b1, 10'd260, 4'd6},  // R6 exact use
    '{1'b0, 2'd1, 10'd0,   10'd10,  1'b1, 10'd470, 4'd3},  // R3 wraps past empty
    '{1'b1, 2'd0, 10'd460, 10'd20,  1'b1, 10'd0,   4'd7},  // R7 merge after
    '{1'b0, 2'd0, 10'd0,   10'd40,  1'b1, 10'd460, 4'd7},
    '{1'b0, 2'd0, 10'd0,   10'd1,   1'b0, 10'd0,   4'd10}, // R10 empty table
    '{1'b1, 2'd0, 10'd100, 10'd50,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd200, 10'd50,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd150, 10'd50,  1'b1, 10'd0,   4'd7},  // R7 merge both sides
    '{1'b0, 2'd2, 10'd0,   10'd151, 1'b0, 10'd0,   4'd7},
    '{1'b0, 2'd2, 10'd0,   10'd150, 1'b1, 10'd100, 4'd7},
    '{1'b1, 2'd0, 10'd0,   10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd10,  10'd10,  1'b1, 10'd0,   4'd7},  // R7 merge before
    '{1'b0, 2'd0, 10'd0,   10'd20,  1'b1, 10'd0,   4'd7},
    '{1'b1, 2'd0, 10'd0,   10'd10,  1'b1, 10'd0,   4'd8},  // fill all entries
    '{1'b1, 2'd0, 10'd20,  10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd40,  10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd60,  10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd80,  10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd100, 10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd120, 10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd140, 10'd10,  1'b1, 10'd0,   4'd8},
    '{1'b1, 2'd0, 10'd300, 10'd50,  1'b0, 10'd0,   4'd9},  // R9 overflow
    '{1'b0, 2'd3, 10'd0,   10'd11,  1'b0, 10'd0,   4'd9},  // R9 nothing inserted
    '{1'b1, 2'd0, 10'd30,  10'd10,  1'b1, 10'd0,   4'd7},  // merge on full table
    '{1'b0, 2'd3, 10'd0,   10'd11,  1'b1, 10'd20,  4'd5},
    '{1'b0, 2'd2, 10'd0,   10'd10,  1'b1, 10'd0,   4'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_free = 1'b0;
  logic [1:0]    req_policy = '0;
  logic [AW-1:0] req_addr = '0, req_size = '0;
  logic          busy, done, ok;
  logic [AW-1:0] grant;
  int            n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  hole_alloc_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_free_i(req_free),
    .req_policy_i(req_policy), .req_addr_i(req_addr), .req_size_i(req_size),
    .busy_o(busy), .done_o(done), .ok_o(ok), .grant_addr_o(grant)
  );

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_req(input logic fr, input logic [1:0] pol, input logic [AW-1:0] a,
                         input logic [AW-1:0] s, output logic r_ok,
                         output logic [AW-1:0] r_g, output int dones);
    @(negedge clk);
    req_valid = 1'b1; req_free = fr; req_policy = pol; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    dones = 0; r_ok = 1'b0; r_g = '0;
    for (int w = 0; w < 30; w++) begin
      if (done) begin dones++; r_ok = ok; r_g = grant; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic          r_ok;
    logic [AW-1:0] r_g;
    int            dn;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i].fr, VEC[i].pol, VEC[i].addr, VEC[i].size, r_ok, r_g, dn);
      check($sformatf("R11 done count v%0d", i), dn, 1);
      check($sformatf("R%0d ok v%0d", VEC[i].req, i), int'(r_ok), int'(VEC[i].ok));
      if (!VEC[i].fr && VEC[i].ok)
        check($sformatf("R%0d grant v%0d", VEC[i].req, i), int'(r_g), int'(VEC[i].grant));
    end

    // R1: reset restores the single full-pool hole
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    rst_n = 1'b1;
    run_req(1'b0, 2'd0, '0, 10'd1000, r_ok, r_g, dn);
    check("R1 full pool ok", int'(r_ok), 1);
    check("R1 full pool grant", int'(r_g), 0);
    run_req(1'b0, 2'd0, '0, 10'd1, r_ok, r_g, dn);
    check("R1 pool used up", int'(r_ok), 0);

    // R11: a request made while busy is dropped
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b0; req_policy = 2'd0; req_addr = '0; req_size = 10'd600;
    @(negedge clk);
    check("R11 busy after accept", int'(busy), 1);
    req_size = 10'd400;
    @(negedge clk);
    req_valid = 1'b0;
    dn = 0;
    for (int w = 0; w < 20; w++) begin
      if (done) begin
        dn++;
        check("R11 first grant", int'(grant), 0);
      end
      @(negedge clk);
    end
    check("R11 one done for two strobes", dn, 1);
    check("R11 idle afterwards", int'(busy), 0);
    run_req(1'b0, 2'd0, '0, 10'd400, r_ok, r_g, dn);
    check("R11 dropped request left space", int'(r_ok), 1);
    check("R11 follow-up grant", int'(r_g), 600);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule